// File: doc/BRIEF.md
# Four-Character Dot-Matrix Refresh Sequencer

This block keeps a four-character, 5x7 LED dot-matrix display lit by refreshing it one column at a time. The display holds a 28-stage serial row register (seven row bits per character), five column-enable lines and an active-low blank line. The sequencer keeps the glyph patterns in an internal frame buffer of four characters by five columns by seven row bits. A host fills the buffer through a write port that takes a character index, a column index and seven row bits.

For each column the sequencer takes a snapshot of that column across all four characters. It shifts the 28 bits out on `ser_data`, using a serial clock `ser_clk` whose high-to-low transition is the display's capture edge. It then drives the matching column line for `DWELL_CYC` cycles and moves on to the next column. The state machine has four states:
- `S_GAP`: dead time, all columns off; the snapshot is taken here.
- `S_HI`: serial clock high; the data bit is presented.
- `S_LO`: serial clock low; the display captures the bit.
- `S_DWELL`: the column is driven.

The transitions are:
- GAP→HI: unconditional.
- HI→LO: unconditional.
- LO→HI: more bits remain.
- LO→DWELL: the 28th bit is done.
- DWELL→HI is not allowed.
- DWELL→GAP: the dwell count expires; the column index advances and wraps from 5 to 1.

A separate blank request drives the active-low blank output and overrides the display without disturbing the sequence.

Top module: `dmx_refresh`

## Requirements
- R1: While `rst` is high and in the cycle after it, `col_drv` is 0, `blank_n` is 0 and `ser_clk` is 1. Reset clears the frame buffer to all zeros. The first column driven afterwards is column 1 (`col_drv` = 5'b00001).
- R2: Between the end of one column drive and the start of the next, `ser_clk` has exactly 28 high-to-low transitions.
- R3: After a column load, display stage p (1 = the stage nearest the data input, 28 = the farthest) holds row r of character c, where p = 7*c + r. Here c is the character index 0..3 written on `wr_char` and r is 1..7. Row r is bit r-1 of `wr_row_bits`. The first bit shifted out is therefore character index 3, row 7, and the last is character index 0, row 1.
- R4: A stored 1 is sent as a 1 and a stored 0 as a 0, with no inversion.
- R5: `col_drv` is all zeros whenever `ser_clk` is low, that is, throughout every shift phase.
- R6: At most one `col_drv` bit is high at a time. Bit k-1 drives column k. Columns are driven in the order 1, 2, 3, 4, 5 and then 1 again.
- R7: Each column drive lasts exactly `DWELL_CYC` clock cycles (default 8).
- R8: After a column drive ends, `ser_clk` stays high for at least one cycle before the next falling edge.
- R9: `ser_data` changes only in cycles where `ser_clk` is high. In a cycle where `ser_clk` is low, it equals its value in the cycle before.
- R10: `blank_n` equals the inverse of `blank_req` one cycle later. Blanking does not stop or reorder the column sequence.
- R11: A buffer write lands in the buffer at once but reaches the display only at the next load of that column, never during the load in progress. A write whose `wr_col` is 5, 6 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Frame buffer write strobe |
| wr_char | input | 2 | Character index 0..3 |
| wr_col | input | 3 | Column index 0..4 (column 1..5) |
| wr_row_bits | input | 7 | Row pattern, bit r-1 = row r |
| blank_req | input | 1 | Request to darken the display |
| ser_clk | output | 1 | Serial clock, idles high, display samples on the fall |
| ser_data | output | 1 | Serial row data |
| col_drv | output | 5 | Column enables, bit k-1 = column k |
| blank_n | output | 1 | Active-low blank to the display |

## Verification
The properties assume `rst` is held for at least one clock edge before the first checked cycle, so every history they consult starts from reset. They also assume `blank_req` is synchronous to `clk`. Write-timing behaviour is defined only against a column load that starts after the write completes. The stimulus therefore changes `blank_req` and the write port only on falling clock edges. It judges a column's image only once an entire load has begun after the last write, and it discards the column whose snapshot may overlap a burst of writes.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    typedef enum logic [1:0] {
        S_GAP   = 2'd0,
        S_HI    = 2'd1,
        S_LO    = 2'd2,
        S_DWELL = 2'd3
    } seq_state_t;

endpackage

// File: rtl/dmx_fbuf.sv
module dmx_fbuf #(
    parameter int N_CHAR = 4,
    parameter int N_COL  = 5,
    parameter int N_ROW  = 7,
    localparam int CHW   = $clog2(N_CHAR),
    localparam int CW    = $clog2(N_COL),
    localparam int BITS  = N_CHAR * N_ROW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CHW-1:0]   wr_char,
    input  logic [CW-1:0]    wr_col,
    input  logic [N_ROW-1:0] wr_row_bits,
    input  logic [CW-1:0]    rd_col,
    output logic [BITS-1:0]  col_word
);

    localparam logic [CW-1:0]  LAST_COL  = CW'(N_COL - 1);
    localparam logic [CHW-1:0] LAST_CHAR = CHW'(N_CHAR - 1);

    logic [N_ROW-1:0] mem [N_CHAR][N_COL];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < N_CHAR; c++)
                for (int k = 0; k < N_COL; k++)
                    mem[c][k] <= '0;
        end else if (wr_en && wr_col <= LAST_COL && wr_char <= LAST_CHAR) begin
            mem[wr_char][wr_col] <= wr_row_bits;
        end
    end

    // Character 0 occupies the low group, so the far character leaves first.
    for (genvar g = 0; g < N_CHAR; g++) begin : g_pack
        assign col_word[g*N_ROW +: N_ROW] = mem[g][rd_col];
    end

endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
    import dmx_pkg::*;
#(
    parameter int N_CHAR    = 4,
    parameter int N_COL     = 5,
    parameter int N_ROW     = 7,
    parameter int DWELL_CYC = 8,
    localparam int CW       = $clog2(N_COL),
    localparam int BITS     = N_CHAR * N_ROW,
    localparam int BCW      = $clog2(BITS),
    localparam int DCW      = $clog2(DWELL_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BITS-1:0]  col_word,
    output logic [CW-1:0]    rd_col,
    output logic             ser_clk,
    output logic             ser_data,
    output logic [N_COL-1:0] col_drv
);

    localparam logic [BCW-1:0] LAST_BIT   = BCW'(BITS - 1);
    localparam logic [CW-1:0]  LAST_COL   = CW'(N_COL - 1);
    localparam logic [DCW-1:0] LAST_DWELL = DCW'(DWELL_CYC - 1);

    seq_state_t      state;
    logic [CW-1:0]   col;
    logic [BCW-1:0]  bit_cnt;
    logic [DCW-1:0]  dwell_cnt;
    logic [BITS-1:0] shreg;

    // State register with its counters and the snapshot shifter.
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_GAP;
            col       <= '0;
            bit_cnt   <= '0;
            dwell_cnt <= '0;
            shreg     <= '0;
        end else begin
            unique case (state)
                S_GAP: begin
                    shreg   <= col_word;
                    bit_cnt <= '0;
                    state   <= S_HI;
                end
                S_HI: begin
                    state <= S_LO;
                end
                S_LO: begin
                    shreg <= shreg << 1;
                    if (bit_cnt == LAST_BIT) begin
                        dwell_cnt <= '0;
                        state     <= S_DWELL;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        state   <= S_HI;
                    end
                end
                S_DWELL: begin
                    if (dwell_cnt == LAST_DWELL) begin
                        col   <= (col == LAST_COL) ? '0 : col + 1'b1;
                        state <= S_GAP;
                    end else begin
                        dwell_cnt <= dwell_cnt + 1'b1;
                    end
                end
                default: state <= S_GAP;
            endcase
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        rd_col   = col;
        ser_data = shreg[BITS-1];
        ser_clk  = 1'b1;
        col_drv  = '0;
        unique case (state)
            S_GAP:   ;
            S_HI:    ;
            S_LO:    ser_clk = 1'b0;
            S_DWELL: col_drv = N_COL'(1) << col;
            default: ;
        endcase
    end

endmodule

// File: rtl/dmx_refresh.sv
module dmx_refresh #(
    parameter int N_CHAR    = 4,
    parameter int N_COL     = 5,
    parameter int N_ROW     = 7,
    parameter int DWELL_CYC = 8,
    localparam int CHW      = $clog2(N_CHAR),
    localparam int CW       = $clog2(N_COL),
    localparam int BITS     = N_CHAR * N_ROW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CHW-1:0]   wr_char,
    input  logic [CW-1:0]    wr_col,
    input  logic [N_ROW-1:0] wr_row_bits,
    input  logic             blank_req,
    output logic             ser_clk,
    output logic             ser_data,
    output logic [N_COL-1:0] col_drv,
    output logic             blank_n
);

    logic [BITS-1:0] col_word;
    logic [CW-1:0]   rd_col;

    dmx_fbuf #(
        .N_CHAR(N_CHAR), .N_COL(N_COL), .N_ROW(N_ROW)
    ) u_fbuf (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_char     (wr_char),
        .wr_col      (wr_col),
        .wr_row_bits (wr_row_bits),
        .rd_col      (rd_col),
        .col_word    (col_word)
    );

    dmx_seq #(
        .N_CHAR(N_CHAR), .N_COL(N_COL), .N_ROW(N_ROW), .DWELL_CYC(DWELL_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .col_word (col_word),
        .rd_col   (rd_col),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .col_drv  (col_drv)
    );

    always_ff @(posedge clk) begin
        if (rst) blank_n <= 1'b0;
        else     blank_n <= ~blank_req;
    end

endmodule

// File: rtl/dmx_refresh_chk.sv
module dmx_refresh_chk #(
    parameter int BITS      = 28,
    parameter int N_COL     = 5,
    parameter int DWELL_CYC = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             blank_req,
    input logic             ser_clk,
    input logic             ser_data,
    input logic [N_COL-1:0] col_drv,
    input logic             blank_n
);

    logic [31:0]      dwell_run;
    logic [31:0]      fall_cnt;
    logic             sclk_q;
    logic [N_COL-1:0] last_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            dwell_run <= '0;
            fall_cnt  <= '0;
            sclk_q    <= 1'b1;
            last_col  <= N_COL'(1) << (N_COL - 1);
        end else begin
            sclk_q    <= ser_clk;
            dwell_run <= (col_drv != '0) ? dwell_run + 1 : '0;
            if (col_drv != '0) begin
                fall_cnt <= '0;
                last_col <= col_drv;
            end else if (sclk_q && !ser_clk) begin
                fall_cnt <= fall_cnt + 1;
            end
        end
    end

    // R1: reset values seen in the first cycle after reset
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (col_drv == '0 && !blank_n && ser_clk));

    // R2: a full load precedes every column drive
    a_r2_full_load: assert property (@(posedge clk) disable iff (rst)
        $rose(|col_drv) |-> fall_cnt == BITS);

    // R5: columns dark while the serial clock is low
    a_r5_cols_off_in_shift: assert property (@(posedge clk) disable iff (rst)
        !ser_clk |-> col_drv == '0);

    // R6: one column at a time, advancing in ring order from column 1
    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col_drv));
    a_r6_ring_order: assert property (@(posedge clk) disable iff (rst)
        $rose(|col_drv) |-> col_drv == {last_col[N_COL-2:0], last_col[N_COL-1]});

    // R7: dwell length
    a_r7_dwell_len: assert property (@(posedge clk) disable iff (rst)
        ($past(col_drv) != '0 && col_drv == '0) |-> dwell_run == DWELL_CYC);
    a_r7_dwell_bound: assert property (@(posedge clk) disable iff (rst)
        (col_drv != '0) |-> dwell_run < DWELL_CYC);

    // R8: dead time after a column drive
    a_r8_dead_time: assert property (@(posedge clk) disable iff (rst)
        ($past(col_drv) != '0 && col_drv == '0) |-> ser_clk);

    // R9: data held across the capture edge
    a_r9_data_stable: assert property (@(posedge clk) disable iff (rst)
        !ser_clk |-> $stable(ser_data));

    // R10: blank follows request one cycle later
    a_r10_blank_follow: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> blank_n == !$past(blank_req));

endmodule

bind dmx_refresh dmx_refresh_chk #(
    .BITS(BITS), .N_COL(N_COL), .DWELL_CYC(DWELL_CYC)
) u_chk (.*);

// File: tb/dmx_refresh_test.sv
module dmx_refresh_test;

    localparam int DWELL = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_char = '0;
    logic [2:0] wr_col = '0;
    logic [6:0] wr_row_bits = '0;
    logic       blank_req = 1'b0;
    logic       ser_clk, ser_data, blank_n;
    logic [4:0] col_drv;

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    bit done = 1'b0;

    logic [6:0]  exp_mem [4][5];
    logic [28:1] disp = '0;
    int          falls = 0;

    dmx_refresh #(.DWELL_CYC(DWELL)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char), .wr_col(wr_col),
        .wr_row_bits(wr_row_bits), .blank_req(blank_req), .ser_clk(ser_clk),
        .ser_data(ser_data), .col_drv(col_drv), .blank_n(blank_n)
    );

    always #2 clk = ~clk;

    // Model of the display's row register: stage 1 takes the new bit.
    always @(negedge ser_clk) begin
        disp  <= {disp[27:1], ser_data};
        falls <= falls + 1;
    end

    // Continuous port checks for R5, R8, R9.
    logic [4:0] prev_col = '0;
    logic       prev_data = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!ser_clk) begin
                mon_checks += 2;
                if (col_drv != '0) begin
                    mon_errors++;
                    $display("FAIL R5: col_drv %0h expected 0 while ser_clk low", col_drv);
                end
                if (ser_data != prev_data) begin
                    mon_errors++;
                    $display("FAIL R9: ser_data %0b expected %0b while ser_clk low", ser_data, prev_data);
                end
            end
            if (prev_col != '0 && col_drv == '0) begin
                mon_checks++;
                if (!ser_clk) begin
                    mon_errors++;
                    $display("FAIL R8: ser_clk %0b expected 1 after column drop", ser_clk);
                end
            end
        end
        prev_col  = col_drv;
        prev_data = ser_data;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [28:1] img_of(input int k);
        logic [28:1] e;
        for (int c = 0; c < 4; c++)
            for (int r = 1; r <= 7; r++)
                e[7*c + r] = exp_mem[c][k][r-1];
        return e;
    endfunction

    task automatic wr(input int c, input int k, input logic [6:0] d);
        wr_en = 1'b1; wr_char = 2'(c); wr_col = 3'(k); wr_row_bits = d;
        if (k < 5) exp_mem[c][k] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Waits for the next column drive; reports column, image, pulses, dwell.
    task automatic grab(output int k, output logic [28:1] img, output int nf, output int dw);
        int f0;
        while (col_drv != '0) @(negedge clk);
        f0 = falls;
        while (col_drv == '0) @(negedge clk);
        nf = falls - f0;
        img = disp;
        k = -1;
        for (int i = 0; i < 5; i++) if (col_drv == 5'(1 << i)) k = i;
        dw = 0;
        while (col_drv != '0) begin dw++; @(negedge clk); end
    endtask

    // One full frame checked against the expected buffer (R2, R3, R6, R7).
    task automatic check_frame(input string req);
        int k, nf, dw, pk;
        logic [28:1] img;
        grab(pk, img, nf, dw);  // discard: may overlap the writes
        for (int n = 0; n < 5; n++) begin
            grab(k, img, nf, dw);
            chk(k == (pk + 1) % 5, "R6", k, (pk + 1) % 5);
            chk(nf == 28, "R2", nf, 28);
            chk(dw == DWELL, "R7", dw, DWELL);
            chk(img == img_of(k), req, int'(img), int'(img_of(k)));
            pk = k;
        end
    endtask

    task automatic t_reset;
        int k, nf, dw;
        logic [28:1] img;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(col_drv == '0, "R1", col_drv, 0);
        chk(blank_n == 1'b0, "R1", blank_n, 0);
        chk(ser_clk == 1'b1, "R1", ser_clk, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(col_drv == '0 && ser_clk == 1'b1, "R1", {col_drv, ser_clk}, 1);
        for (int c = 0; c < 4; c++) for (int j = 0; j < 5; j++) exp_mem[c][j] = '0;
        grab(k, img, nf, dw);
        chk(k == 0, "R1", k, 0);
        chk(img == '0, "R1", int'(img), 0);
        chk(nf == 28, "R2", nf, 28);
        chk(dw == DWELL, "R7", dw, DWELL);
    endtask

    task automatic t_fill_walk;
        for (int c = 0; c < 4; c++)
            for (int j = 0; j < 5; j++)
                wr(c, j, 7'(1 << ((c + 2*j) % 7)));
        check_frame("R3");
    endtask

    task automatic t_single_bits;
        // char index 3 row 7 must land at stage 28, char index 0 row 1 at stage 1
        for (int c = 0; c < 4; c++) for (int j = 0; j < 5; j++) wr(c, j, 7'h00);
        wr(3, 2, 7'h40);
        wr(0, 4, 7'h01);
        check_frame("R3");
    endtask

    task automatic t_polarity;
        for (int c = 0; c < 4; c++) for (int j = 0; j < 5; j++) wr(c, j, 7'h7F);
        check_frame("R4");
        for (int c = 0; c < 4; c++) for (int j = 0; j < 5; j++) wr(c, j, (c % 2 == 0) ? 7'h55 : 7'h2A);
        check_frame("R4");
    endtask

    task automatic t_write_timing;
        int k, nk, nf, dw;
        logic [28:1] img, old_img;
        grab(k, img, nf, dw);
        @(negedge clk); @(negedge clk);  // snapshot of the next column taken
        nk = (k + 1) % 5;
        old_img = img_of(nk);
        for (int c = 0; c < 4; c++) wr(c, nk, ~exp_mem[c][nk]);
        grab(k, img, nf, dw);
        chk(k == nk, "R11", k, nk);
        chk(img == old_img, "R11", int'(img), int'(old_img));
        for (int n = 0; n < 5; n++) grab(k, img, nf, dw);
        chk(k == nk, "R11", k, nk);
        chk(img == img_of(nk), "R11", int'(img), int'(img_of(nk)));
        // column indices 5..7 are ignored
        wr(0, 5, 7'h7F);
        wr(3, 7, 7'h7F);
        wr(1, 6, 7'h7F);
        check_frame("R11");
    endtask

    task automatic t_blank;
        int k, pk, nf, dw;
        logic [28:1] img;
        @(negedge clk);
        blank_req = 1'b1;
        @(negedge clk);
        chk(blank_n == 1'b0, "R10", blank_n, 0);
        grab(pk, img, nf, dw);
        grab(k, img, nf, dw);
        chk(k == (pk + 1) % 5, "R10", k, (pk + 1) % 5);
        chk(blank_n == 1'b0, "R10", blank_n, 0);
        blank_req = 1'b0;
        @(negedge clk);
        chk(blank_n == 1'b1, "R10", blank_n, 1);
    endtask

    initial begin
        t_reset();
        t_fill_walk();
        t_single_bits();
        t_polarity();
        t_write_timing();
        t_blank();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errors + 1);
            $finish;
        end
    end

endmodule